// File: doc/BRIEF.md
# Paced Audio Sample Output Port

A byte-wide peripheral that sits on a byte-addressed system bus and feeds an 8-bit parallel DAC input at a fixed sample rate. Software writes one sample value into a data byte, then polls a status byte until a readiness flag comes back. The port, not the software, sets the output pace: an internal divider derived from the system clock frequency and the sample rate produces a tick, and on each tick a waiting sample moves to the DAC holding register.

The port claims exactly two byte addresses, one for the sample and one for status. Both are even, so the odd neighbours belong to other hardware and the port does not answer them. Reading status has no effect on the data path. A write that arrives while a sample is still waiting replaces it, which is the hazard the readiness flag lets software avoid.

Top module: `pcm_sample_port`

## Requirements
- R1: After reset the DAC output is 0, the load strobe is low, and a status read returns 8'h40, meaning ready.
- R2: A bus write to the sample address (default 16'hFF78, octal 177570) clears the ready flag from the next cycle on, until a tick consumes the sample.
- R3: A bus read of the status address (default 16'hFF7A, octal 177572) returns the ready flag in bit 6. Bits 7 and 5..0 always read 0.
- R4: A rate tick occurs once every CLK_HZ/RATE_HZ clock cycles. On a tick with a sample waiting, the sample appears on the DAC output one cycle later, the load strobe is high for that one cycle, and ready returns to 1.
- R5: On a tick with no sample waiting, the DAC output holds its previous value and the load strobe stays low.
- R6: Accesses to any other address, including sample+1 and status+1, are ignored. No state changes, read data is 0 and the hit output is low. The hit output is high only for a read or write to one of the two port addresses.
- R7: Status reads have no side effects. A waiting sample and the ready flag are unchanged by any number of status reads.
- R8: A second write before the next tick overwrites the waiting sample, and the tick delivers the latest value.
- R9: When a write coincides with a tick, the tick delivers the sample that was already waiting, and the new write becomes the waiting sample (ready stays 0).
- R10: A bus read of the sample address returns the last value written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per byte write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte, combinational, 0 when not selected |
| bus_hit | output | 1 | High when the current access targets this port |
| dac_data | output | 8 | Sample currently presented to the DAC |
| dac_load | output | 1 | One-cycle pulse when dac_data takes a new sample |

## Verification
A behavioural model with an integer tick counter and a pending flag runs alongside the port and is compared on every clock. Directed sequences separate the delivery cases. One has a single write per tick period. One has two writes in a period, which shows overwrite versus queueing. One puts a write on the exact tick cycle, which shows the ordering between consuming and loading. One leaves the port idle across ticks, which shows a held output versus a spurious strobe. A pseudo-random phase mixes reads and writes across the two port addresses, their odd neighbours and an unrelated address, so decode leaks and read side effects become visible as mismatches.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    typedef logic [7:0] byte_t;

    localparam logic [15:0] DEF_SAMPLE_ADDR = 16'o177570;
    localparam logic [15:0] DEF_STATUS_ADDR = 16'o177572;
    localparam int unsigned READY_POS       = 6;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_SAMPLE = 2'd1,
        SEL_STATUS = 2'd2
    } port_sel_e;

    typedef struct packed {
        byte_t held;
        logic  pending;
        byte_t dac;
        logic  load;
    } play_state_t;

endpackage

// File: rtl/pcm_rate_div.sv
module pcm_rate_div #(
    parameter int unsigned DIV = 1133,
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = (st_q.cnt == CW'(DIV - 1));
        if (tick) st_d.cnt = '0;
        else      st_d.cnt = st_q.cnt + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DIV - 1));

endmodule

// File: rtl/pcm_bus_decode.sv
module pcm_bus_decode
    import pcm_port_pkg::*;
#(
    parameter int unsigned ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] SAMPLE_ADDR = ADDR_W'(DEF_SAMPLE_ADDR),
    parameter logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(DEF_STATUS_ADDR)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output port_sel_e         sel,
    output logic              wr_sample,
    output logic              hit
);

    always_comb begin
        if (addr == SAMPLE_ADDR)      sel = SEL_SAMPLE;
        else if (addr == STATUS_ADDR) sel = SEL_STATUS;
        else                          sel = SEL_NONE;
        wr_sample = wr && (sel == SEL_SAMPLE);
        hit       = (wr || rd) && (sel != SEL_NONE);
    end

endmodule

// File: rtl/pcm_play_core.sv
module pcm_play_core
    import pcm_port_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick,
    input  logic  wr_sample,
    input  byte_t wdata,
    output byte_t held,
    output logic  ready,
    output byte_t dac,
    output logic  load
);

    play_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.load = 1'b0;
        // a tick consumes what was waiting before this edge
        if (tick && s_q.pending) begin
            s_d.dac     = s_q.held;
            s_d.load    = 1'b1;
            s_d.pending = 1'b0;
        end
        // a write in the same cycle becomes the next waiting sample
        if (wr_sample) begin
            s_d.held    = wdata;
            s_d.pending = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign held  = s_q.held;
    assign ready = ~s_q.pending;
    assign dac   = s_q.dac;
    assign load  = s_q.load;

    // R2
    wr_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sample |=> !ready);

    // R4
    tick_delivers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ready) |=> (load && dac == $past(held)));

    // R5
    idle_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ready) |=> (!load && $stable(dac)));

    // R8
    wr_latest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sample |=> (held == $past(wdata)));

endmodule

// File: rtl/pcm_sample_port.sv
module pcm_sample_port
    import pcm_port_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int unsigned RATE_HZ     = 44_100,
    parameter logic [15:0] SAMPLE_ADDR = DEF_SAMPLE_ADDR,
    parameter logic [15:0] STATUS_ADDR = DEF_STATUS_ADDR
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        bus_hit,
    output logic [7:0]  dac_data,
    output logic        dac_load
);

    localparam int unsigned DIV = (CLK_HZ / RATE_HZ > 0) ? (CLK_HZ / RATE_HZ) : 1;

    port_sel_e sel;
    logic      wr_sample;
    logic      tick;
    logic      ready;
    byte_t     held;

    pcm_rate_div #(.DIV(DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    pcm_bus_decode #(
        .ADDR_W      (16),
        .SAMPLE_ADDR (SAMPLE_ADDR),
        .STATUS_ADDR (STATUS_ADDR)
    ) u_dec (
        .addr      (bus_addr),
        .wr        (bus_wr),
        .rd        (bus_rd),
        .sel       (sel),
        .wr_sample (wr_sample),
        .hit       (bus_hit)
    );

    pcm_play_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .wr_sample (wr_sample),
        .wdata     (bus_wdata),
        .held      (held),
        .ready     (ready),
        .dac       (dac_data),
        .load      (dac_load)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (sel)
                SEL_STATUS: bus_rdata[READY_POS] = ready;
                SEL_SAMPLE: bus_rdata = held;
                default:    bus_rdata = '0;
            endcase
        end
    end

    // R3
    status_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == STATUS_ADDR) |->
            (bus_rdata[7] == 1'b0 && bus_rdata[5:0] == 6'd0 && bus_rdata[READY_POS] == ready));

    // R6
    hit_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hit |-> (bus_addr == SAMPLE_ADDR || bus_addr == STATUS_ADDR));

    // R6
    foreign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != SAMPLE_ADDR && bus_addr != STATUS_ADDR) |-> (bus_rdata == 8'd0 && !bus_hit));

endmodule

// File: tb/pcm_sample_port_tb_top.sv
module pcm_sample_port_tb_top;

    localparam int CLK_HZ  = 1000;
    localparam int RATE_HZ = 100;
    localparam int DIV     = CLK_HZ / RATE_HZ;
    localparam logic [15:0] A_SMP = 16'hFF78;
    localparam logic [15:0] A_STA = 16'hFF7A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_hit;
    logic [7:0]  dac_data;
    logic        dac_load;

    always #10 clk = ~clk;

    pcm_sample_port #(.CLK_HZ(CLK_HZ), .RATE_HZ(RATE_HZ)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_hit(bus_hit), .dac_data(dac_data), .dac_load(dac_load)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // behavioural reference
    int m_cnt, m_held, m_pend, m_dac, m_load;
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_cnt = 0; m_held = 0; m_pend = 0; m_dac = 0; m_load = 0;
        end else begin
            int t;
            t = (m_cnt == DIV - 1);
            m_cnt = t ? 0 : m_cnt + 1;
            m_load = 0;
            if (t && m_pend) begin m_dac = m_held; m_load = 1; m_pend = 0; end
            if (bus_wr && bus_addr == A_SMP) begin m_held = bus_wdata; m_pend = 1; end
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_rdata();
        if (!bus_rd) return 0;
        if (bus_addr == A_STA) return m_pend ? 8'h00 : 8'h40;
        if (bus_addr == A_SMP) return m_held;
        return 0;
    endfunction

    function automatic int exp_hit();
        return int'((bus_rd || bus_wr) && (bus_addr == A_SMP || bus_addr == A_STA));
    endfunction

    task automatic compare();
        chk("R4 dac_data", dac_data, m_dac);
        chk("R4 dac_load", dac_load, m_load);
        chk("R3 bus_rdata", bus_rdata, exp_rdata());
        chk("R6 bus_hit", bus_hit, exp_hit());
    endtask

    task automatic sync();
        @(negedge clk);
        if (rst_n) compare();
    endtask

    task automatic drv(bit w, bit r, logic [15:0] a, logic [7:0] d);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    endtask

    task automatic wait_load(output int at);
        at = -1;
        for (int i = 0; i < 3 * DIV; i++) begin
            sync();
            if (dac_load) begin at = cyc; break; end
        end
    endtask

    bit done = 1'b0;

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int t1, t2;
        logic [15:0] lfsr;
        drv(0, 0, 16'h0, 8'h0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        sync();
        // R1: reset state
        chk("R1 dac_data", dac_data, 0);
        chk("R1 dac_load", dac_load, 0);
        drv(0, 1, A_STA, 0); #1;
        chk("R1 status ready", bus_rdata, 8'h40);
        sync();
        // R2: write clears ready
        drv(1, 0, A_SMP, 8'h5A); sync();
        drv(0, 1, A_STA, 0); #1;
        chk("R2 ready cleared", bus_rdata, 8'h00);
        // R10: sample readback
        drv(0, 1, A_SMP, 0); #1;
        chk("R10 sample readback", bus_rdata, 8'h5A);
        // R7: repeated status reads until the tick delivers
        drv(0, 1, A_STA, 0);
        wait_load(t1);
        chk("R7 sample survives status reads", dac_data, 8'h5A);
        #1 chk("R4 ready after tick", bus_rdata, 8'h40);
        // R4: period between deliveries
        drv(1, 0, A_SMP, 8'hC3); sync(); drv(0, 0, 0, 0);
        wait_load(t2);
        chk("R4 tick period", t2 - t1, DIV);
        chk("R4 delivered", dac_data, 8'hC3);
        // R8: overwrite before tick
        drv(1, 0, A_SMP, 8'h11); sync();
        drv(1, 0, A_SMP, 8'h22); sync();
        drv(0, 0, 0, 0);
        wait_load(t1);
        chk("R8 latest delivered", dac_data, 8'h22);
        // R6: foreign addresses ignored
        drv(1, 0, 16'hFF79, 8'h77); sync();
        drv(1, 0, 16'hFF7B, 8'h77); sync();
        drv(1, 0, 16'h1234, 8'h77); sync();
        drv(0, 1, 16'hFF7B, 0); #1;
        chk("R6 odd neighbour read", bus_rdata, 0);
        chk("R6 odd neighbour hit", bus_hit, 0);
        drv(0, 1, A_STA, 0); #1;
        chk("R6 still ready", bus_rdata, 8'h40);
        drv(0, 0, 0, 0);
        // R5: idle ticks hold output
        t2 = 0;
        for (int i = 0; i < 2 * DIV + 2; i++) begin
            sync();
            if (dac_load) t2++;
        end
        chk("R5 no strobe when idle", t2, 0);
        chk("R5 output held", dac_data, 8'h22);
        // R9: write on the tick cycle
        drv(1, 0, A_SMP, 8'h33); sync(); drv(0, 0, 0, 0);
        for (int i = 0; i < 2 * DIV; i++) begin
            if (m_cnt == DIV - 1) break;
            sync();
        end
        drv(1, 0, A_SMP, 8'h44); sync();
        drv(0, 1, A_STA, 0); #1;
        chk("R9 older sample out", dac_data, 8'h33);
        chk("R9 strobe", dac_load, 1);
        chk("R9 new sample pending", bus_rdata, 8'h00);
        drv(0, 0, 0, 0);
        wait_load(t1);
        chk("R9 queued sample out", dac_data, 8'h44);
        // mixed traffic against the model
        lfsr = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            logic [15:0] a;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (lfsr[2:0])
                3'd0, 3'd1: a = A_SMP;
                3'd2, 3'd3: a = A_STA;
                3'd4:       a = 16'hFF79;
                3'd5:       a = 16'hFF7B;
                default:    a = 16'h1234;
            endcase
            drv(lfsr[3] & lfsr[4] & lfsr[5], lfsr[6], a, lfsr[15:8]);
            sync();
        end
        drv(0, 0, 0, 0);
        sync();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule